// File: doc/BRIEF.md
# Dual-Rate Pair Serializer

This block turns 16-bit unsigned conversion results into a stream of 2-bit pairs. Each word goes out as eight consecutive slots on a 2-bit data bus, most significant pair first. The value 16'h0000 stands for the darkest input and 16'hFFFF for full scale. The block also generates the master clock that a receiver uses to capture the pairs.

The block runs on an internal clock at twice the master-clock rate, and the master clock output toggles on every internal cycle. There are two timing modes, picked by a plain mode pin:

- **Single-edge mode:** a new pair appears only together with a rising master-clock edge, so a word takes 16 internal cycles.
- **Double-edge mode:** a new pair appears at every master-clock edge, so a word takes 8 internal cycles.

A word-start marker is high during the first slot of every word.

Words enter through a valid/ready handshake, and a word is taken on any internal clock edge where both are high. The rules for back-pressure are:

- Ready is high only when the serializer is idle or is sending the last slot of the current word. The producer may therefore present the next word early and hold it until it is taken.
- When consecutive words use the same mode, they follow each other with no idle slot between them.
- The mode pin is sampled together with the word, so a later change of the pin never affects a word already taken.
- A single-edge word may only start on an edge where the master clock rises. After a double-edge word, ready can therefore stay low for one extra internal cycle before a single-edge word is taken.

Top module: `pair_stream_tx`

## Requirements
- R1: While the synchronous active-low reset is asserted, the data bus is 0, word-start is low and the master clock output is low.
- R2: Pairs of a word leave most significant first: slot k carries bits [15-2k:14-2k], so slot 0 carries [15:14] and slot 7 carries [1:0].
- R3: In single-edge mode (mode pin 0) each slot lasts two internal cycles and begins in the cycle where the master clock output has just gone high.
- R4: In double-edge mode (mode pin 1) each slot lasts one internal cycle.
- R5: The master clock output changes value on every internal clock cycle after reset.
- R6: Word-start is high exactly during slot 0 of each word and low otherwise.
- R7: When no word is being sent, the data bus is 0 and word-start is low.
- R8: Back-to-back words in the same mode stream with no gap: words held valid are accepted every 16 internal cycles in single-edge mode and every 8 in double-edge mode.
- R9: The mode is captured when a word is accepted; changing the mode pin while that word is being sent does not change its timing.
- R10: A word is accepted only on an edge with valid and ready both high; ready is low during slot 0 of a word and every accepted word appears on the bus exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the master-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample word is present |
| in_ready | output | 1 | Serializer will take the word on this edge |
| in_data | input | 16 | Unsigned straight-binary sample word |
| ddr_mode | input | 1 | 0 = single-edge, 1 = double-edge; sampled with the word |
| mclk_out | output | 1 | Generated master clock |
| dout | output | 2 | Current 2-bit slot |
| word_start | output | 1 | High during slot 0 of each word |

## Verification
The assertions make only two assumptions about the inputs: that they change synchronously to the internal clock, and that they carry no unknown values once reset is released. They assume no holding rule on valid, data or mode, because the block samples those inputs only at the edge where a word is accepted.

The bench drives every input just after the falling internal edge. It reads ready after the inputs have settled, so the pin values seen by the design at the rising edge match what the bench recorded. Random traffic mixes the two modes, gaps of different lengths and mode changes while a word is in flight.

// File: rtl/pstx_pkg.sv
package pstx_pkg;
  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/pstx_clk_phase.sv
module pstx_clk_phase (
  input  logic clk,
  input  logic rst_n,
  output logic mclk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) mclk_q <= 1'b0;
    else        mclk_q <= ~mclk_q;
  end

  // R5: generated clock alternates every internal cycle
  assert_mclk_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mclk_q != $past(mclk_q)));
endmodule

// File: rtl/pstx_slot_seq.sv
module pstx_slot_seq
  import pstx_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  edge_mode_e mode_in,
  input  logic       mclk_q,
  output logic       in_ready,
  output logic       load,
  output logic       shift,
  output logic       busy,
  output logic       first_slot,
  output edge_mode_e mode_q
);
  logic [CNT_W-1:0] cnt;
  logic             adv_ok;
  logic             start_ok;
  logic             last;

  // a slot may end on this edge: any edge in double mode, rising edge in single mode
  assign adv_ok     = busy ? ((mode_q == EDGE_DOUBLE) || !mclk_q) : 1'b1;
  assign start_ok   = (mode_in == EDGE_DOUBLE) || !mclk_q;
  assign last       = (cnt == CNT_W'(SLOTS - 1));
  assign in_ready   = adv_ok && start_ok && (!busy || last);
  assign load       = in_valid && in_ready;
  assign shift      = busy && adv_ok && !last;
  assign first_slot = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mode_q <= EDGE_SINGLE;
    end else if (load) begin
      busy   <= 1'b1;
      cnt    <= '0;
      mode_q <= mode_in;
    end else if (shift) begin
      cnt <= cnt + CNT_W'(1);
    end else if (busy && adv_ok && last) begin
      busy <= 1'b0;
    end
  end

  // R9: captured mode holds for the rest of a word
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt != '0)) |-> $stable(mode_q));

  // R10: a word only starts after a completed handshake
  assert_accept_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/pstx_pair_shift.sv
module pstx_pair_shift #(
  parameter int WORD_W = 16,
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              busy,
  input  logic [WORD_W-1:0] din,
  output logic [PAIR_W-1:0] dout
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= shreg << PAIR_W;
  end

  assign dout = busy ? shreg[WORD_W-1 -: PAIR_W] : '0;

  // R2: top pair of a freshly accepted word is the first slot
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(din[WORD_W-1 -: PAIR_W])));
endmodule

// File: rtl/pair_stream_tx.sv
module pair_stream_tx
  import pstx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PAIR_W = 2,
  localparam int SLOTS = WORD_W / PAIR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              ddr_mode,
  output logic              mclk_out,
  output logic [PAIR_W-1:0] dout,
  output logic              word_start
);
  logic       load;
  logic       shift;
  logic       busy;
  edge_mode_e mode_q;

  pstx_clk_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .mclk_q (mclk_out)
  );

  pstx_slot_seq #(.SLOTS(SLOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_in    (edge_mode_e'(ddr_mode)),
    .mclk_q     (mclk_out),
    .in_ready   (in_ready),
    .load       (load),
    .shift      (shift),
    .busy       (busy),
    .first_slot (word_start),
    .mode_q     (mode_q)
  );

  pstx_pair_shift #(.WORD_W(WORD_W), .PAIR_W(PAIR_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .shift (shift),
    .busy  (busy),
    .din   (in_data),
    .dout  (dout)
  );

  // R3: single-edge words begin just after a rising master-clock edge
  assert_sdr_start_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(word_start) && (mode_q == EDGE_SINGLE)) |-> mclk_out);

  // R3: in single-edge mode data holds across the falling master-clock edge
  assert_sdr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mode_q == EDGE_SINGLE) && !mclk_out) |-> $stable(dout));

  // R7: an idle bus carries no marker
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!word_start && (dout == '0)));
endmodule

// File: tb/pair_stream_tx_bench.sv
`timescale 1ns/1ps
module pair_stream_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        ddr_mode = 1'b0;
  logic        mclk_out;
  logic [1:0]  dout;
  logic        word_start;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [16:0] exp_q[$];
  bit          active = 0;
  bit          have_prev = 0;
  logic        prev_mclk = 1'b0;
  logic [16:0] cur = '0;
  int          idx = 0;
  int          step = 1;
  int          slot = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pair_stream_tx u_pair_stream_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .ddr_mode   (ddr_mode),
    .mclk_out   (mclk_out),
    .dout       (dout),
    .word_start (word_start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_pair(input logic [15:0] w, input int s);
    return int'((w >> (2 * (7 - s))) & 16'h3);
  endfunction

  // receiver-side monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      have_prev = 0;
      active = 0;
    end else begin
      if (have_prev) check(mclk_out != prev_mclk, "R5 toggle", int'(mclk_out), int'(!prev_mclk));
      prev_mclk = mclk_out;
      have_prev = 1;
      if (!active && word_start) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected word", 1, 0);
        else begin
          cur = exp_q.pop_front();
          active = 1;
          idx = 0;
          step = cur[16] ? 1 : 2;
        end
      end
      if (active) begin
        slot = idx / step;
        if (step == 1) check(int'(dout) == exp_pair(cur[15:0], slot), "R2/R4 pair", int'(dout), exp_pair(cur[15:0], slot));
        else           check(int'(dout) == exp_pair(cur[15:0], slot), "R2/R3 pair", int'(dout), exp_pair(cur[15:0], slot));
        check(word_start == (slot == 0), "R6 marker", int'(word_start), int'(slot == 0));
        if (step == 2 && (idx % 2) == 0) check(mclk_out == 1'b1, "R3 slot at rise", int'(mclk_out), 1);
        idx++;
        if (idx == 8 * step) active = 0;
      end else begin
        check(dout == 2'b00 && !word_start, "R7 idle", int'({word_start, dout}), 0);
      end
    end
  end

  task automatic send(input logic [15:0] w, input logic m, output int acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    ddr_mode = m;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        exp_q.push_back({m, w});
        acc = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n, input bit wiggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'($urandom);
      if (wiggle) ddr_mode = ~ddr_mode;
    end
  endtask

  initial begin
    int a0, a1, a2;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    check(dout == 2'b00, "R1 dout", int'(dout), 0);
    check(word_start == 1'b0, "R1 word_start", int'(word_start), 0);
    check(mclk_out == 1'b0, "R1 mclk", int'(mclk_out), 0);
    rst_n = 1'b1;
    idle(3, 0);

    // directed corners: full-scale, black, patterned
    send(16'hFFFF, 1'b1, a0);
    #2; check(in_ready == 1'b0, "R10 ready low in slot0", int'(in_ready), 0);
    send(16'h0000, 1'b1, a0);
    send(16'hA5C3, 1'b0, a0);
    #2; check(in_ready == 1'b0, "R10 ready low in slot0 single", int'(in_ready), 0);
    // R9: mode pin toggles while the single-edge word is in flight
    idle(20, 1);

    // R8: back-to-back, double-edge
    send(16'h1234, 1'b1, a0);
    send(16'h5678, 1'b1, a1);
    send(16'h9ABC, 1'b1, a2);
    check(a1 - a0 == 8, "R8 R4 interval", a1 - a0, 8);
    check(a2 - a1 == 8, "R8 R4 interval", a2 - a1, 8);
    idle(2, 0);
    // R8: back-to-back, single-edge
    send(16'h0F0F, 1'b0, a0);
    send(16'hF0F0, 1'b0, a1);
    send(16'h3C96, 1'b0, a2);
    check(a1 - a0 == 16, "R8 R3 interval", a1 - a0, 16);
    check(a2 - a1 == 16, "R8 R3 interval", a2 - a1, 16);
    idle(20, 0);

    // random traffic
    for (int n = 0; n < 250; n++) begin
      int g;
      send(16'($urandom), 1'($urandom), a0);
      g = int'($urandom % 4);
      if (g != 0) idle(g, 1'($urandom));
    end
    idle(40, 0);
    check(exp_q.size() == 0, "R10 all words delivered", exp_q.size(), 0);
    check(!active, "R7 stream finished", int'(active), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule